// File: doc/BRIEF.md
# Systolic Matrix Repeated-Squaring Array

This block multiplies two dense 3x3 matrices on a grid of inner-product-step cells. Each cell computes one step `s + a*b` per clock. The first operand moves left-to-right along the rows. The second operand is shifted in from the right edge, then held in place while the pass runs. Partial sums climb each column from bottom to top. The bottom of every column starts from zero. Operand rows enter skewed by one cycle per index, so that each element of A meets the matching element of B together with the partial sum it belongs to.

A start strobe captures both matrices and an iteration count `q`. The first pass always computes A×B. Each of the `q` further passes squares the previous product: the 32-bit results leaving the top of the array are cut to their low 16 bits and used as both operands of the next pass. Setting B = A therefore yields A^2, A^4, A^8 and so on, without any wire longer than one cell pitch. Only the final product leaves the block. It is streamed in row-major order with a valid flag and followed by a one-cycle done pulse.

Top module: `systolic_sq_array`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `res_valid` and `done` are low.
- R2: With `iters` = 0 the streamed result is A×B, with element (i,j) of each input matrix at bits `[(i*N+j)*16 +: 16]` of `mat_a` / `mat_b`.
- R3: With `iters` = q the block performs exactly q+1 multiplications. The first is A×B. Each later one squares the previous product after it has been truncated to its low 16 bits.
- R4: The result is emitted one element per cycle, in row-major order (0,0), (0,1), … (N-1,N-1), over N*N consecutive cycles.
- R5: The first result element is visible (4N-1)·(q+1)+1 rising edges after the edge that accepted `start`. `res_valid` is high only during the N*N-cycle output window.
- R6: `done` is high for exactly one cycle: the cycle right after the last result element. It is low at all other times.
- R7: A `start` that arrives while a computation is in progress (any phase, including output) is ignored. Its matrices and count have no effect on the result or its timing.
- R8: Accumulation wraps modulo 2^32. For example, all-0xFFFF operands give 3·0xFFFE0001 mod 2^32 = 0xFFFA0003 in every element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation; only honoured while idle |
| iters | input | 4 | Number of squaring passes after the first product |
| mat_a | input | 144 | First operand matrix, row-major, 16 bits per element |
| mat_b | input | 144 | Second operand matrix, row-major, 16 bits per element |
| res_valid | output | 1 | Result element valid |
| res_data | output | 32 | Result element |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
The bench targets the identity product, a mismatched A×B (a design that swapped operand flow directions or skewed a row by one cycle would pair the wrong a and b and scramble elements), all-ones-16-bit operands (a narrow accumulator would lose the carry out of bit 31 differently) and chains of 1, 2 and 15 squarings with values large enough that the low-16-bit truncation matters (feeding back the full 32 bits, or stopping one pass early or late, gives different numbers and a shifted output window). It also pulses `start` with different matrices and count both during a pass and during the output burst. A design that reloaded on that strobe would change the data or move the burst.

// File: rtl/sqa_pkg.sv
package sqa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOADB,
    ST_STREAM,
    ST_OUT
  } sqa_state_e;
endpackage

// File: rtl/sqa_pe.sv
// Inner-product-step cell: registered s_out = s_in + a*b (mod 2^AW).
module sqa_pe #(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [AW-1:0] s_in,
  output logic [AW-1:0] s_out
);
  always_ff @(posedge clk) begin
    if (rst) s_out <= '0;
    else     s_out <= s_in + (AW'(a_in) * AW'(b_in));
  end
endmodule

// File: rtl/sqa_grid.sv
// N x N cell grid. Row k holds the k-th inner-product step. A moves right
// through one register per cell, B shifts in from the right edge and parks,
// and partial sums rise one row per cycle.
module sqa_grid #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            b_shift,
  input  logic [N*DW-1:0] b_feed,
  input  logic [N*DW-1:0] a_feed,
  output logic [N*AW-1:0] top_sum
);
  logic [DW-1:0] b_q    [N][N];
  logic [DW-1:0] a_pipe [N][N-1];
  logic [DW-1:0] a_in_w [N][N];
  logic [AW-1:0] s_w    [N][N];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      a_in_w[k][0] = a_feed[k*DW +: DW];
      for (int j = 1; j < N; j++) a_in_w[k][j] = a_pipe[k][j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        for (int j = 0; j < N-1; j++) a_pipe[k][j] <= '0;
        for (int j = 0; j < N; j++)   b_q[k][j]    <= '0;
      end
    end else begin
      for (int k = 0; k < N; k++) begin
        for (int j = 0; j < N-1; j++) a_pipe[k][j] <= a_in_w[k][j];
        if (b_shift) begin
          for (int j = 0; j < N-1; j++) b_q[k][j] <= b_q[k][j+1];
          b_q[k][N-1] <= b_feed[k*DW +: DW];
        end
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic [AW-1:0] s_below;
      if (k == 0) begin : g_bot
        assign s_below = '0;
      end else begin : g_mid
        assign s_below = s_w[k-1][j];
      end
      sqa_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk   (clk),
        .rst   (rst),
        .a_in  (a_in_w[k][j]),
        .b_in  (b_q[k][j]),
        .s_in  (s_below),
        .s_out (s_w[k][j])
      );
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_top
    assign top_sum[j*AW +: AW] = s_w[N-1][j];
  end
endmodule

// File: rtl/systolic_sq_array.sv
module systolic_sq_array
  import sqa_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int IW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IW-1:0]     iters,
  input  logic [N*N*DW-1:0] mat_a,
  input  logic [N*N*DW-1:0] mat_b,
  output logic              res_valid,
  output logic [AW-1:0]     res_data,
  output logic              done
);
  localparam int NN         = N * N;
  localparam int STREAM_LEN = 3 * N - 1;
  localparam int CW         = $clog2(STREAM_LEN + NN + 1);

  sqa_state_e    state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] pass_q, iters_q;
  logic          last_q;
  logic          fb;

  logic [DW-1:0] op_a  [NN];
  logic [DW-1:0] op_b  [NN];
  logic [AW-1:0] res_m [NN];

  logic [N*DW-1:0] a_feed, b_feed;
  logic [N*AW-1:0] top_sum;

  // Operand source: captured matrices on the first pass, truncated product after.
  always_comb begin
    int idx;
    int row;
    idx    = 0;
    row    = 0;
    fb     = (pass_q != '0);
    a_feed = '0;
    b_feed = '0;
    for (int k = 0; k < N; k++) begin
      if (state == ST_LOADB) begin
        idx = k * N + int'(cnt);
        b_feed[k*DW +: DW] = fb ? res_m[idx][DW-1:0] : op_b[idx];
      end
      if (state == ST_STREAM) begin
        row = int'(cnt) - k;
        if (row >= 0 && row < N) begin
          idx = row * N + k;
          a_feed[k*DW +: DW] = fb ? res_m[idx][DW-1:0] : op_a[idx];
        end
      end
    end
  end

  sqa_grid #(.N(N), .DW(DW), .AW(AW)) u_grid (
    .clk     (clk),
    .rst     (rst),
    .b_shift (state == ST_LOADB),
    .b_feed  (b_feed),
    .a_feed  (a_feed),
    .top_sum (top_sum)
  );

  // Operand and result storage (no reset, register-file style).
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && start) begin
      for (int e = 0; e < NN; e++) begin
        op_a[e] <= mat_a[e*DW +: DW];
        op_b[e] <= mat_b[e*DW +: DW];
      end
    end
    if (state == ST_STREAM) begin
      for (int j = 0; j < N; j++) begin
        if (int'(cnt) >= j + N && int'(cnt) < j + 2 * N)
          res_m[(int'(cnt) - j - N) * N + j] <= top_sum[j*AW +: AW];
      end
    end
  end

  // Sequencer and registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pass_q    <= '0;
      iters_q   <= '0;
      last_q    <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      done      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      last_q    <= 1'b0;
      done      <= last_q;
      case (state)
        ST_IDLE: begin
          if (start) begin
            iters_q <= iters;
            pass_q  <= '0;
            cnt     <= '0;
            state   <= ST_LOADB;
          end
        end
        ST_LOADB: begin
          if (cnt == CW'(N - 1)) begin
            cnt   <= '0;
            state <= ST_STREAM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STREAM: begin
          if (cnt == CW'(STREAM_LEN - 1)) begin
            cnt <= '0;
            if (pass_q == iters_q) begin
              state <= ST_OUT;
            end else begin
              pass_q <= pass_q + 1'b1;
              state  <= ST_LOADB;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OUT: begin
          res_valid <= 1'b1;
          res_data  <= res_m[int'(cnt)];
          if (cnt == CW'(NN - 1)) begin
            last_q <= 1'b1;
            cnt    <= '0;
            state  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sqa_chk.sv
module sqa_chk #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          res_valid,
  input logic          done,
  input logic          busy,
  input logic [IW-1:0] iters_q,
  input logic [IW-1:0] pass_q,
  input logic [DW-1:0] op_a0
);
  localparam int NN = N * N;
  localparam int LW = $clog2(NN + 2);

  logic [LW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)            run_len <= '0;
    else if (res_valid) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  assert_quiet_reset_R1: assert property (@(posedge clk)
    rst |=> (!res_valid && !done));

  assert_pass_bound_R3: assert property (@(posedge clk) disable iff (rst)
    pass_q <= iters_q);

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(res_valid) |-> (run_len == LW'(NN)));

  assert_done_after_burst_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(res_valid) |-> done);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_source_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(res_valid) && !res_valid));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(iters_q) && $stable(op_a0)));
endmodule

bind systolic_sq_array sqa_chk #(.N(N), .DW(DW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .res_valid (res_valid),
  .done      (done),
  .busy      (state != sqa_pkg::ST_IDLE),
  .iters_q   (iters_q),
  .pass_q    (pass_q),
  .op_a0     (op_a[0])
);

// File: tb/tb_systolic_sq_array.sv
module tb_systolic_sq_array;
  localparam int N    = 3;
  localparam int DW   = 16;
  localparam int AW   = 32;
  localparam int IW   = 4;
  localparam int NN   = N * N;
  localparam int PCYC = 4 * N - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst, start;
  logic [IW-1:0]     iters;
  logic [NN*DW-1:0]  mat_a, mat_b;
  logic              res_valid, done;
  logic [AW-1:0]     res_data;

  int errs   = 0;
  int checks = 0;
  int cyc    = 0;

  logic [AW-1:0] exp_r [NN];

  systolic_sq_array #(.N(N), .DW(DW), .AW(AW), .IW(IW)) dut (
    .clk(clk), .rst(rst), .start(start), .iters(iters),
    .mat_a(mat_a), .mat_b(mat_b),
    .res_valid(res_valid), .res_data(res_data), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errs++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NN*DW-1:0] mk(input int s0, input int st);
    logic [NN*DW-1:0] v;
    for (int e = 0; e < NN; e++) v[e*DW +: DW] = DW'(s0 + st * e);
    return v;
  endfunction

  function automatic logic [NN*DW-1:0] ident();
    logic [NN*DW-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) v[(i*N+i)*DW +: DW] = 1;
    return v;
  endfunction

  // Reference: q+1 products, each later pass squares the truncated result.
  task automatic build_expect(input logic [NN*DW-1:0] a_f, input logic [NN*DW-1:0] b_f,
                              input int q);
    logic [DW-1:0] ca [NN];
    logic [DW-1:0] cb [NN];
    logic [AW-1:0] acc;
    for (int e = 0; e < NN; e++) begin
      ca[e] = a_f[e*DW +: DW];
      cb[e] = b_f[e*DW +: DW];
    end
    for (int p = 0; p <= q; p++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          acc = '0;
          for (int k = 0; k < N; k++) acc += AW'(ca[i*N+k]) * AW'(cb[k*N+j]);
          exp_r[i*N+j] = acc;
        end
      for (int e = 0; e < NN; e++) begin
        ca[e] = exp_r[e][DW-1:0];
        cb[e] = exp_r[e][DW-1:0];
      end
    end
  endtask

  // One run, compared against the model on every cycle.
  task automatic run(input logic [NN*DW-1:0] a_f, input logic [NN*DW-1:0] b_f,
                     input int q, input string tag, input bit poke);
    int first;
    build_expect(a_f, b_f, q);
    first = PCYC * (q + 1) + 1;
    @(negedge clk);
    mat_a = a_f; mat_b = b_f; iters = IW'(q); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= first + NN + 3; c++) begin
      if (poke && (c == 4 || c == first + 2)) begin
        mat_a = ~a_f; mat_b = ~b_f; iters = ~IW'(q); start = 1'b1;  // R7
      end
      if (poke && (c == 5 || c == first + 3)) start = 1'b0;
      chk("R5", "res_valid", longint'(res_valid),
          longint'(c >= first && c < first + NN));
      chk("R6", "done", longint'(done), longint'(c == first + NN));
      if (c >= first && c < first + NN && res_valid)
        chk({tag, " R4"}, $sformatf("element %0d", c - first),
            longint'(res_data), longint'(exp_r[c - first]));
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; iters = '0; mat_a = '0; mat_b = '0;
    repeat (3) @(negedge clk);
    chk("R1", "res_valid in reset", longint'(res_valid), 0);
    chk("R1", "done in reset", longint'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "res_valid after reset", longint'(res_valid), 0);
    chk("R1", "done after reset", longint'(done), 0);

    run(ident(), mk(1, 1), 0, "R2", 1'b0);                  // identity x M
    run(mk(3, 2), mk(20, 7), 0, "R2", 1'b0);                // general A x B
    run({NN{16'hFFFF}}, {NN{16'hFFFF}}, 0, "R8", 1'b0);     // 32-bit wrap
    run(mk(1, 1), mk(1, 1), 1, "R3", 1'b0);                 // A^4
    run(mk(200, 37), mk(200, 37), 2, "R3 R8", 1'b0);        // truncated feedback
    run(mk(2, 3), mk(5, 1), 2, "R3", 1'b0);                 // A x B then squares
    run(mk(1, 1), mk(1, 1), 15, "R3", 1'b0);                // longest chain
    run(mk(7, 11), mk(9, 5), 1, "R7", 1'b1);                // start while busy
    run(mk(4, 1), mk(6, 2), 0, "R7", 1'b0);                 // clean restart after

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule